// File: doc/BRIEF.md
# Abstract Command Status Controller

This block holds the status and control side of a debug abstract-command interface. A host reaches it through a small 32-bit register port. The block keeps a busy flag and a sticky 3-bit error code. It guards the command register so that a command is launched only when the block is idle and no error is latched. It also stores the argument data words, the program-buffer words and the two auto-execute masks for those words.

When a command is accepted, the block raises `cmdStart` for one cycle and presents the command word. The execution engine later reports completion and a result code. Reading or writing a data or program-buffer word whose auto-execute bit is set launches the held command again.

Host accesses made while a command is running are refused. Such an access records a busy error, but only if no error is already latched. Errors are removed by writing ones to the bits to be cleared.

Top module: `absCmdStatus`

Register map (word index on `regAddr`):

| Index | Register | Contents |
|---|---|---|
| 0x00 | status | error code [2:0], write-one-to-clear; busy [4]; data-word count [11:8]; program-word count [20:16] |
| 0x01 | command | 32-bit command word |
| 0x02 | auto-execute | data-word mask [11:0]; program-word mask [31:16] |
| 0x08 + i | data word i | for i below `DATA_WORDS` |
| 0x20 + i | program word i | for i below `PROG_WORDS` |

Error codes: 0 none, 1 busy, 2 not supported, 3 exception, 4 hart in wrong state or unavailable, 5 bus error, 7 other.

## Requirements
- R1: After reset, busy is 0, the error code is 0, `cmdStart` is 0, both auto-execute masks read 0 and every data word reads 0.
- R2: A command write (index 0x01) made while the block is idle with the error code at 0 stores the word. In the cycle after that write, `cmdStart` is 1 for exactly one cycle, `cmdWord` equals the written word, and status bit 4 (busy) reads 1.
- R3: Busy stays 1 until a cycle with `engDone` high and then reads 0. That cycle's `engErr` is latched into the error code only if the code is 0. An `engDone` pulse while idle has no effect.
- R4: A status write made while idle clears each error-code bit whose written bit in [2:0] is 1, and leaves the other bits unchanged.
- R5: A command write made while the error code is nonzero is ignored. No start occurs and the command register keeps its old value.
- R6: While busy, any of the following sets the error code to 1 if it is 0 and otherwise leaves it unchanged: a write to the status, command or auto-execute register, or a read or write of an implemented data or program word.
- R7: While busy, writes to data words, program words, the command register and the auto-execute register leave the stored values unchanged. Reads of those registers still return the stored values.
- R8: When idle with the error code at 0, a read or write of an implemented data word whose mask bit [i] is set, or of a program word whose mask bit [16+i] is set, launches the held command. In that case `cmdStart` pulses as in R2, `cmdWord` is unchanged, and any written value is stored.
- R9: An access that would trigger auto-execution makes no start while the error code is nonzero. A write in that case is still stored.
- R10: The status register reports `DATA_WORDS` in [11:8] and `PROG_WORDS` in [20:16]. Mask bits for unimplemented words read 0. Indices of unimplemented words read 0, and writes to them are ignored without error.
- R11: If `engDone` arrives in the same cycle as a busy-time access, the error code becomes 1 (when it was 0) and the engine's result code is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (counts as an access) |
| regAddr | input | 6 | Register word index |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data of the addressed register |
| engDone | input | 1 | Engine completion pulse |
| engErr | input | 3 | Engine result code, valid with engDone |
| cmdStart | output | 1 | One-cycle command launch pulse |
| cmdWord | output | 32 | Command word held for the engine |

## Verification
Two events can fall in the same clock cycle: the engine's completion report and a host access that arrives while a command is still running. The bench drives both in one cycle, once in a directed case and many more times through random stimulus that asserts `engDone` alongside arbitrary accesses. The outcome is judged through a status read on the following cycle. That read must show busy cleared and an error code of 1 rather than the engine's code, or the earlier code unchanged if one was already latched.

// File: rtl/absCmdPkg.sv
package absCmdPkg;
  localparam int ADDR_W   = 6;
  localparam int ERR_W    = 3;
  localparam int MAX_DATA = 12;
  localparam int MAX_PROG = 16;

  localparam logic [ADDR_W-1:0] ADR_STATUS = 6'h00;
  localparam logic [ADDR_W-1:0] ADR_CMD    = 6'h01;
  localparam logic [ADDR_W-1:0] ADR_AUTO   = 6'h02;
  localparam logic [ADDR_W-1:0] ADR_DATA0  = 6'h08;
  localparam logic [ADDR_W-1:0] ADR_PROG0  = 6'h20;

  localparam logic [ERR_W-1:0] ERR_NONE = 3'd0;
  localparam logic [ERR_W-1:0] ERR_BUSY = 3'd1;

  // decode and write strobes passed from control to datapath
  typedef struct packed {
    logic       selStatus;
    logic       selCmd;
    logic       selAuto;
    logic       selData;
    logic       selProg;
    logic       cmdWe;
    logic       autoWe;
    logic       dataWe;
    logic       progWe;
    logic [3:0] wordIdx;
  } dpStrobe_t;
endpackage

// File: rtl/absCmdCtrl.sv
module absCmdCtrl
  import absCmdPkg::*;
#(
  parameter int DATA_WORDS = 4,
  parameter int PROG_WORDS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [ERR_W-1:0]    errClr,
  input  logic                engDone,
  input  logic [ERR_W-1:0]    engErr,
  input  logic [MAX_DATA-1:0] dataMask,
  input  logic [MAX_PROG-1:0] progMask,
  output dpStrobe_t           stb,
  output logic                busy,
  output logic [ERR_W-1:0]    errCode,
  output logic                cmdStart
);
  localparam logic [ADDR_W-1:0] DATA_N = ADDR_W'(DATA_WORDS);
  localparam logic [ADDR_W-1:0] PROG_N = ADDR_W'(PROG_WORDS);

  logic              busyQ, startQ;
  logic [ERR_W-1:0]  errQ;
  logic [ADDR_W-1:0] dataOff, progOff;
  logic              isStatus, isCmd, isAuto, isData, isProg;
  logic              wordAcc, busyAcc, autoHit, errIdle, launch;
  logic [15:0]       dataMaskWide;

  assign dataOff  = regAddr - ADR_DATA0;
  assign progOff  = regAddr - ADR_PROG0;
  assign isStatus = (regAddr == ADR_STATUS);
  assign isCmd    = (regAddr == ADR_CMD);
  assign isAuto   = (regAddr == ADR_AUTO);
  assign isData   = (regAddr >= ADR_DATA0) && (dataOff < DATA_N);
  assign isProg   = (regAddr >= ADR_PROG0) && (progOff < PROG_N);

  assign dataMaskWide = {4'b0, dataMask};
  assign wordAcc = (regWrEn | regRdEn) & (isData | isProg);
  assign busyAcc = busyQ & ((regWrEn & (isStatus | isCmd | isAuto)) | wordAcc);
  assign autoHit = wordAcc & ((isData & dataMaskWide[dataOff[3:0]]) |
                              (isProg & progMask[progOff[3:0]]));
  assign errIdle = (errQ == ERR_NONE);
  assign launch  = ~busyQ & errIdle & ((regWrEn & isCmd) | autoHit);

  always_comb begin
    stb.selStatus = isStatus;
    stb.selCmd    = isCmd;
    stb.selAuto   = isAuto;
    stb.selData   = isData;
    stb.selProg   = isProg;
    stb.cmdWe     = ~busyQ & errIdle & regWrEn & isCmd;
    stb.autoWe    = ~busyQ & regWrEn & isAuto;
    stb.dataWe    = ~busyQ & regWrEn & isData;
    stb.progWe    = ~busyQ & regWrEn & isProg;
    stb.wordIdx   = isData ? dataOff[3:0] : progOff[3:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      startQ <= 1'b0;
      errQ   <= ERR_NONE;
    end else begin
      startQ <= launch;
      if (launch)                busyQ <= 1'b1;
      else if (busyQ && engDone) busyQ <= 1'b0;

      if (busyQ) begin
        if (errIdle) begin
          if (busyAcc)      errQ <= ERR_BUSY;
          else if (engDone) errQ <= engErr;
        end
      end else if (regWrEn && isStatus) begin
        errQ <= errQ & ~errClr;
      end
    end
  end

  assign busy     = busyQ;
  assign errCode  = errQ;
  assign cmdStart = startQ;

  // R2: the launch pulse coincides with busy and lasts one cycle
  p_start_with_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |-> busyQ);
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> !cmdStart);
  p_busy_rise_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> cmdStart);
  // R5 / R9: a latched error blocks any launch
  p_no_start_on_err_r5: assert property (@(posedge clk) disable iff (!rstN)
    (errQ != ERR_NONE) |=> !cmdStart);
  // R6: a latched error is not overwritten while busy
  p_err_sticky_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && errQ != ERR_NONE) |=> (errQ == $past(errQ)));
  // R4: a nonzero code only loses bits, never gains them
  p_err_only_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(errQ) != ERR_NONE && errQ != $past(errQ)) |-> ((errQ & ~$past(errQ)) == '0));
endmodule

// File: rtl/absCmdData.sv
module absCmdData
  import absCmdPkg::*;
#(
  parameter int DATA_WORDS = 4,
  parameter int PROG_WORDS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           stb,
  input  logic [31:0]         wrData,
  input  logic                busy,
  input  logic [ERR_W-1:0]    errCode,
  output logic [MAX_DATA-1:0] dataMask,
  output logic [MAX_PROG-1:0] progMask,
  output logic [31:0]         cmdWord,
  output logic [31:0]         rdData
);
  localparam logic [MAX_DATA-1:0] DATA_IMPL = MAX_DATA'((1 << DATA_WORDS) - 1);
  localparam logic [MAX_PROG-1:0] PROG_IMPL = MAX_PROG'((1 << PROG_WORDS) - 1);

  logic [31:0]         cmdQ;
  logic [MAX_DATA-1:0] dataMaskQ;
  logic [MAX_PROG-1:0] progMaskQ;
  logic [31:0]         dataMem [DATA_WORDS];
  logic [31:0]         progMem [PROG_WORDS];
  logic [31:0]         statusWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ      <= '0;
      dataMaskQ <= '0;
      progMaskQ <= '0;
      for (int i = 0; i < DATA_WORDS; i++) dataMem[i] <= '0;
      for (int i = 0; i < PROG_WORDS; i++) progMem[i] <= '0;
    end else begin
      if (stb.cmdWe) cmdQ <= wrData;
      if (stb.autoWe) begin
        dataMaskQ <= wrData[MAX_DATA-1:0] & DATA_IMPL;
        progMaskQ <= wrData[31:16] & PROG_IMPL;
      end
      for (int i = 0; i < DATA_WORDS; i++)
        if (stb.dataWe && stb.wordIdx == 4'(i)) dataMem[i] <= wrData;
      for (int i = 0; i < PROG_WORDS; i++)
        if (stb.progWe && stb.wordIdx == 4'(i)) progMem[i] <= wrData;
    end
  end

  assign statusWord = {11'b0, 5'(PROG_WORDS), 4'b0, 4'(DATA_WORDS),
                       3'b0, busy, 1'b0, errCode};

  always_comb begin
    rdData = '0;
    if (stb.selStatus)    rdData = statusWord;
    else if (stb.selCmd)  rdData = cmdQ;
    else if (stb.selAuto) rdData = {progMaskQ, 4'b0, dataMaskQ};
    else if (stb.selData) begin
      for (int i = 0; i < DATA_WORDS; i++)
        if (stb.wordIdx == 4'(i)) rdData = dataMem[i];
    end else if (stb.selProg) begin
      for (int i = 0; i < PROG_WORDS; i++)
        if (stb.wordIdx == 4'(i)) rdData = progMem[i];
    end
  end

  assign dataMask = dataMaskQ;
  assign progMask = progMaskQ;
  assign cmdWord  = cmdQ;

  // R7: control never issues a storage write while a command runs
  p_no_write_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(stb.dataWe || stb.progWe || stb.cmdWe || stb.autoWe));
  // R7: stored command is held across a busy cycle
  p_cmd_hold_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (cmdQ == $past(cmdQ)));
endmodule

// File: rtl/absCmdStatus.sv
module absCmdStatus
  import absCmdPkg::*;
#(
  parameter int DATA_WORDS = 4,
  parameter int PROG_WORDS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [5:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        engDone,
  input  logic [2:0]  engErr,
  output logic        cmdStart,
  output logic [31:0] cmdWord
);
  dpStrobe_t           stb;
  logic                busy;
  logic [ERR_W-1:0]    errCode;
  logic [MAX_DATA-1:0] dataMask;
  logic [MAX_PROG-1:0] progMask;

  absCmdCtrl #(.DATA_WORDS(DATA_WORDS), .PROG_WORDS(PROG_WORDS)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .errClr(regWrData[ERR_W-1:0]), .engDone(engDone),
    .engErr(engErr), .dataMask(dataMask), .progMask(progMask), .stb(stb),
    .busy(busy), .errCode(errCode), .cmdStart(cmdStart)
  );

  absCmdData #(.DATA_WORDS(DATA_WORDS), .PROG_WORDS(PROG_WORDS)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWrData), .busy(busy),
    .errCode(errCode), .dataMask(dataMask), .progMask(progMask),
    .cmdWord(cmdWord), .rdData(regRdData)
  );
endmodule

// File: tb/sim_absCmdStatus.sv
module sim_absCmdStatus;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_N = 4;
  localparam int PROG_N = 8;
  localparam logic [5:0] A_STATUS = 6'h00, A_CMD = 6'h01, A_AUTO = 6'h02,
                         A_DATA0 = 6'h08, A_PROG0 = 6'h20;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 0, regRdEn = 0, engDone = 0;
  logic [5:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [2:0] engErr = '0;
  logic [31:0] regRdData, cmdWord;
  logic cmdStart;

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model state
  bit          mBusy = 0;
  logic [2:0]  mErr = 0;
  logic [31:0] mCmd = 0;
  logic [11:0] mDMask = 0;
  logic [15:0] mPMask = 0;
  logic [31:0] mData [12];
  logic [31:0] mProg [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  absCmdStatus #(.DATA_WORDS(DATA_N), .PROG_WORDS(PROG_N)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .engDone(engDone), .engErr(engErr), .cmdStart(cmdStart), .cmdWord(cmdWord)
  );

  function automatic bit isD(logic [5:0] a);
    return a >= A_DATA0 && a < A_DATA0 + 6'(DATA_N);
  endfunction
  function automatic bit isP(logic [5:0] a);
    return a >= A_PROG0 && a < A_PROG0 + 6'(PROG_N);
  endfunction

  function automatic logic [31:0] mRead(logic [5:0] a);
    if (a == A_STATUS)
      return {11'b0, 5'(PROG_N), 4'b0, 4'(DATA_N), 3'b0, mBusy, 1'b0, mErr};
    if (a == A_CMD)  return mCmd;
    if (a == A_AUTO) return {mPMask, 4'b0, mDMask};
    if (isD(a)) return mData[a - A_DATA0];
    if (isP(a)) return mProg[a - A_PROG0];
    return 32'h0;
  endfunction

  function automatic bit mStep(bit w, bit r, logic [5:0] a, logic [31:0] d,
                               bit dn, logic [2:0] code);
    bit st = 0, acc;
    bit word = (w || r) && (isD(a) || isP(a));
    if (mBusy) begin
      acc = (w && (a == A_STATUS || a == A_CMD || a == A_AUTO)) || word;
      if (mErr == 0) begin
        if (acc) mErr = 3'd1;
        else if (dn) mErr = code;
      end
      if (dn) mBusy = 0;
    end else begin
      if (w) begin
        if (a == A_STATUS) mErr = mErr & ~d[2:0];
        if (a == A_CMD && mErr == 0) begin mCmd = d; st = 1; end
        if (a == A_AUTO) begin
          mDMask = d[11:0] & 12'((1 << DATA_N) - 1);
          mPMask = d[31:16] & 16'((1 << PROG_N) - 1);
        end
        if (isD(a)) mData[a - A_DATA0] = d;
        if (isP(a)) mProg[a - A_PROG0] = d;
      end
      if (word && mErr == 0 &&
          ((isD(a) && mDMask[a - A_DATA0]) || (isP(a) && mPMask[a - A_PROG0])))
        st = 1;
      if (st) mBusy = 1;
    end
    return st;
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, sample read before the edge, start after it
  task automatic cyc(bit w, bit r, logic [5:0] a, logic [31:0] d,
                     bit dn, logic [2:0] code, string tag);
    bit st;
    logic [31:0] er;
    regWrEn = w; regRdEn = r; regAddr = a; regWrData = d;
    engDone = dn; engErr = code;
    #1;
    if (r) begin
      er = mRead(a);
      chk(regRdData, er, tag);
    end
    st = mStep(w, r, a, d, dn, code);
    @(posedge clk); @(negedge clk);
    regWrEn = 0; regRdEn = 0; engDone = 0;
    chk(32'(cmdStart), 32'(st), {tag, " start"});
    if (st) chk(cmdWord, mCmd, {tag, " word"});
  endtask

  task automatic rdStat(string tag);
    cyc(0, 1, A_STATUS, 0, 0, 0, tag);
  endtask

  function automatic logic [2:0] pickCode();
    case ($urandom_range(0, 5))
      0: return 3'd0;
      1: return 3'd2;
      2: return 3'd3;
      3: return 3'd4;
      4: return 3'd5;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [5:0] pickAddr();
    case ($urandom_range(0, 5))
      0: return A_STATUS;
      1: return A_CMD;
      2: return A_AUTO;
      3: return A_DATA0 + 6'($urandom_range(0, DATA_N));
      default: return A_PROG0 + 6'($urandom_range(0, PROG_N));
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 12; i++) mData[i] = 0;
    for (int i = 0; i < 16; i++) mProg[i] = 0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk(32'(cmdStart), 0, "R1 start");
    rdStat("R1 status");
    cyc(0, 1, A_DATA0, 0, 0, 0, "R1 data0");
    cyc(0, 1, A_AUTO, 0, 0, 0, "R1 masks");
    // R10 unimplemented word
    cyc(1, 0, A_DATA0 + 6'(DATA_N), 32'hFFFF_FFFF, 0, 0, "R10 unimpl wr");
    cyc(0, 1, A_DATA0 + 6'(DATA_N), 0, 0, 0, "R10 unimpl rd");
    rdStat("R10 status");
    // R2 launch
    cyc(1, 0, A_CMD, 32'hA5A5_0001, 0, 0, "R2 cmd");
    rdStat("R2 busy");
    // R6/R7 write while busy
    cyc(1, 0, A_DATA0, 32'hDEAD_BEEF, 0, 0, "R7 busy wr");
    rdStat("R6 err busy");
    cyc(0, 1, A_DATA0, 0, 0, 0, "R7 data kept");
    // R3 completion does not overwrite
    cyc(0, 0, 0, 0, 1, 3'd3, "R3 done");
    rdStat("R3 idle");
    cyc(1, 0, A_STATUS, 32'h1, 0, 0, "R4 clr");
    rdStat("R4 cleared");
    cyc(1, 0, A_CMD, 32'h11, 0, 0, "R2 cmd2");
    cyc(0, 0, 0, 0, 1, 3'd5, "R3 done5");
    rdStat("R3 code latched");
    // R5 ignored command
    cyc(1, 0, A_CMD, 32'h22, 0, 0, "R5 cmd blocked");
    cyc(0, 1, A_CMD, 0, 0, 0, "R5 cmd kept");
    // R4 partial clears
    cyc(1, 0, A_STATUS, 32'h4, 0, 0, "R4 clr bit2");
    rdStat("R4 partial");
    cyc(1, 0, A_STATUS, 32'h1, 0, 0, "R4 clr bit0");
    rdStat("R4 zero");
    // R10/R8 masks and auto-execute
    cyc(1, 0, A_AUTO, 32'hFFFF_0002 | 32'h0000_0FF0, 0, 0, "R10 mask wr");
    cyc(0, 1, A_AUTO, 0, 0, 0, "R10 mask rd");
    cyc(1, 0, A_AUTO, (32'h1 << 18) | 32'h2, 0, 0, "R8 mask set");
    cyc(1, 0, A_DATA0 + 6'd1, 32'h1234, 0, 0, "R8 data hit");
    cyc(0, 0, 0, 0, 1, 3'd0, "R8 done");
    cyc(0, 1, A_PROG0 + 6'd2, 0, 0, 0, "R8 prog read hit");
    cyc(0, 0, 0, 0, 1, 3'd0, "R8 done2");
    cyc(0, 1, A_DATA0 + 6'd1, 0, 0, 0, "R8 data read hit");
    cyc(0, 0, 0, 0, 1, 3'd0, "R8 done3");
    // R9 suppression under error
    cyc(1, 0, A_CMD, 32'h33, 0, 0, "R2 cmd3");
    cyc(1, 0, A_AUTO, 32'h0, 0, 0, "R6 auto busy");
    cyc(0, 0, 0, 0, 1, 3'd0, "R3 done4");
    cyc(1, 0, A_DATA0 + 6'd1, 32'h55, 0, 0, "R9 no start");
    cyc(0, 1, A_DATA0 + 6'd1, 0, 0, 0, "R9 stored");
    cyc(0, 1, A_AUTO, 0, 0, 0, "R7 mask kept");
    cyc(1, 0, A_STATUS, 32'h7, 0, 0, "R4 clr all");
    // R11 coincidence
    cyc(1, 0, A_CMD, 32'h44, 0, 0, "R2 cmd4");
    cyc(1, 0, A_STATUS, 32'h0, 1, 3'd2, "R11 coincide");
    rdStat("R11 status");
    cyc(1, 0, A_STATUS, 32'h7, 0, 0, "R4 clr");
    cyc(0, 0, 0, 0, 1, 3'd4, "R3 idle done");
    rdStat("R3 idle ignored");

    // random mix with coincident completions
    for (int n = 0; n < 600; n++) begin
      logic [5:0] a = pickAddr();
      int op = $urandom_range(0, 3);
      bit dn = mBusy && ($urandom_range(0, 2) == 0);
      logic [31:0] d = (a == A_STATUS) ? 32'($urandom_range(0, 7)) : $urandom;
      if (op == 0) cyc(0, 0, 0, 0, dn, pickCode(), "R3 rnd done");
      else if (op == 1) cyc(0, 1, a, 0, dn, pickCode(), "R8 rnd rd");
      else cyc(1, 0, a, d, dn, pickCode(), "R6 rnd wr");
      rdStat("R11 rnd status");
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule